// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is an SPI master that a processor runs one byte at a time through four 32-bit registers on a simple strobed bus. Software sets the mode, the clock divider and the chip-select choice in the control word. It writes outgoing bytes into a transmit queue through the data port. It then sets the run flag. From that point the engine takes bytes from the transmit queue, shifts each one out on the serial lines and places the byte that comes back into a receive queue. Software reads the received bytes back through the same data port.

Serial clock polarity and phase are selectable. Three select lines are provided, and the active level of each can be chosen. A three-wire option releases the data pin so that a device can drive it back. A single interrupt line reports "idle with nothing left to send" and "receive queue filling up". The selected line stays asserted across any number of bytes until software drops the run flag. Setting the run flag with an empty transmit queue reports idle at once.

Top module: `spiRegMaster`

## Requirements
- R1: After reset the control word (offset 0x0) reads 0x00050000, which is the idle flag at bit 16 and the transmit-has-room flag at bit 18. The divider (offset 0x8) reads 0. All select lines are high, the serial clock is low and the interrupt is low.
- R2: Each byte is shifted out MSB first, and exactly one byte is received into the receive queue for each byte sent. Control bit 3 sets the clock idle level and bit 2 the phase. Phase 0 captures on the first clock edge of a bit and phase 1 on the second. Between bytes the clock rests at the idle level.
- R3: The divider is written at offset 0x8 and its bit 0 is ignored, so a write of 5 reads back 4. Each clock half period lasts divider/2 core cycles. A divider of 0 gives a half period of 32768 cycles.
- R4: Control bits 1:0 select line 0, 1 or 2, and a value of 3 selects none. Bit 7 is the run flag, and setting it asserts the selected line. Bits 21, 22 and 23 make lines 0, 1 and 2 active-high. Bit 6 makes the selected line active-high. A line that is not asserted sits at the inverse of its active level. The line stays asserted between bytes until bit 7 is cleared.
- R5: Setting the run flag with an empty transmit queue and no byte in flight sets status bit 16 at once. If bit 9 is set, this also raises the interrupt.
- R6: The interrupt is (bit16 AND bit9) OR (bit19 AND bit10), and it is gated by the run flag.
- R7: The transmit and receive queues are 16 deep. A write to the data port (offset 0x4) while the transmit queue is full is dropped. A read of the data port while the receive queue is empty returns 0 and changes nothing.
- R8: Status bits are as follows. Bit 17 means the receive queue is non-empty. Bit 18 means the transmit queue is not full. Bit 19 means the receive queue holds 12 or more bytes. Bit 20 means the receive queue is full.
- R9: Writing 1 to control bit 4 empties the transmit queue, and writing 1 to bit 5 empties the receive queue. Both bits read back as 0.
- R10: With control bit 12 set, the data output enable `mosiOe` is low and received bits are taken from `mosiIn` instead of `miso`.
- R11: No new byte starts while the receive queue is full. A waiting byte starts once a receive byte has been read out.
- R12: Offset 0xC reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe; data appears one cycle later |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosiOe | output | 1 | Output enable for the data pin |
| mosiIn | input | 1 | Data pin input path, used in three-wire reads |
| miso | input | 1 | Serial data in |
| chipSel | output | 3 | Select lines, level per configured polarity |
| irq | output | 1 | Interrupt request |

## Verification
A device model on the bus answers each byte in the configured mode. It is fed five combinations of polarity, phase, divider and byte pattern. These include 0x01 against 0x80 and all-ones against all-zeros, so a reversed bit order, a capture on the wrong edge or a lost last bit each yields a different byte on one side. The clock-rate checks measure half periods at 3 cycles and at 32768 cycles, which tells correct halving of the divider apart from an off-by-one or a missing zero case. Queue tests push the transmit side past 16 entries and drain the receive side through the 12-entry threshold. This separates dropped writes, stalls caused by a full receive queue, and the level at which the interrupt is raised.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int WORD_W = 8;
  localparam int DIV_W  = 16;
  localparam int NUM_CS = 3;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic              clrTx;
    logic              clrRx;
    logic [WORD_W-1:0] wrByte;
  } strobe_t;

  typedef struct packed {
    logic             active;
    logic             cpol;
    logic             cpha;
    logic             threeWireRd;
    logic [DIV_W-1:0] halfLen;
  } cfg_t;

  typedef struct packed {
    logic              busy;
    logic              txEmpty;
    logic              txFull;
    logic              rxEmpty;
    logic              rxFull;
    logic              rxHigh;
    logic [WORD_W-1:0] rxHead;
  } stat_t;
endpackage

// File: rtl/spiFifo.sv
module spiFifo #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 16,
  parameter int HIGH_MARK = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             high
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= wrData;
  end

  assign head  = mem[rdPtr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign high  = (count >= CNT_W'(HIGH_MARK));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop && !clr) |=> (count == $past(count))); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !push && !clr) |=> empty); // R7
endmodule

// File: rtl/spiShift.sv
module spiShift import spiRegPkg::*; #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  cfg_t    cfg,
  input  logic    misoIn,
  input  logic    dataPinIn,
  output stat_t   stat,
  output logic    sclk,
  output logic    mosi,
  output logic    mosiOe
);
  localparam int HIGH_MARK = (3 * FIFO_DEPTH) / 4;
  localparam int EDGES     = 2 * WORD_W;
  localparam int EDGE_W    = $clog2(EDGES);

  logic              busy;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [WORD_W-1:0] txSh, rxSh, rxNext, rxByte, txHead;
  logic start, edgeNow, leading, capture, launch, lastEdge, inBit;
  logic txEmpty, txFull, rxEmpty, rxFull, rxHigh, txHighUnused;

  spiFifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH), .HIGH_MARK(HIGH_MARK)) txFifo_i (
    .clk(clk), .rstN(rstN), .clr(strb.clrTx), .push(strb.txPush), .pop(start),
    .wrData(strb.wrByte), .head(txHead), .empty(txEmpty), .full(txFull),
    .high(txHighUnused));

  spiFifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH), .HIGH_MARK(HIGH_MARK)) rxFifo_i (
    .clk(clk), .rstN(rstN), .clr(strb.clrRx), .push(lastEdge), .pop(strb.rxPop),
    .wrData(rxByte), .head(stat.rxHead), .empty(rxEmpty), .full(rxFull),
    .high(rxHigh));

  assign start    = !busy && cfg.active && !txEmpty && !rxFull;
  assign edgeNow  = busy && (divCnt == cfg.halfLen - 1'b1);
  assign leading  = !edgeCnt[0];
  assign capture  = edgeNow && (cfg.cpha ? !leading : leading);
  assign launch   = edgeNow && (cfg.cpha ? (leading && edgeCnt != '0) : !leading);
  assign lastEdge = edgeNow && (edgeCnt == EDGE_W'(EDGES - 1));
  assign inBit    = cfg.threeWireRd ? dataPinIn : misoIn;
  assign rxNext   = {rxSh[WORD_W-2:0], inBit};
  assign rxByte   = capture ? rxNext : rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclk    <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
      txSh    <= txHead;
      sclk    <= cfg.cpol;
    end else if (busy) begin
      if (edgeNow) begin
        divCnt  <= '0;
        sclk    <= ~sclk;
        edgeCnt <= edgeCnt + 1'b1;
        if (capture)  rxSh <= rxNext;
        if (launch)   txSh <= {txSh[WORD_W-2:0], 1'b0};
        if (lastEdge) busy <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end else begin
      sclk <= cfg.cpol;
    end
  end

  assign mosi   = txSh[WORD_W-1];
  assign mosiOe = !cfg.threeWireRd;

  assign stat.busy    = busy;
  assign stat.txEmpty = txEmpty;
  assign stat.txFull  = txFull;
  assign stat.rxEmpty = rxEmpty;
  assign stat.rxFull  = rxFull;
  assign stat.rxHigh  = rxHigh;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $stable(cfg.cpol)) |-> (sclk == cfg.cpol)); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (mosi == $past(mosi))); // R2
  AST_NO_START_RXFULL: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !busy) |=> !busy); // R11
endmodule

// File: rtl/spiRegs.sv
module spiRegs import spiRegPkg::*; #(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  stat_t             stat,
  output strobe_t           strb,
  output cfg_t              cfg,
  output logic [NUM_CS-1:0] chipSel,
  output logic              irq
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;
  localparam int B_CLRTX = 4;
  localparam int B_CLRRX = 5;

  logic [1:0]        regSel, csSel;
  logic              cpha, cpol, csPolShared, active, intDoneEn, intRxEn, threeWire;
  logic [NUM_CS-1:0] csPolLine;
  logic [DIV_W-1:0]  divReg;
  logic [BUS_W-1:0]  ctrlWord, rdNext;
  logic              done, wrCtrl;
  logic              unusedBits;

  assign regSel = busAddr[3:2];
  assign wrCtrl = busWrEn && (regSel == SEL_CTRL);
  assign unusedBits = ^{busAddr[1:0], busWrData[BUS_W-1:24], busWrData[20:13], busWrData[11], busWrData[8]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSel <= '0; cpha <= 1'b0; cpol <= 1'b0; csPolShared <= 1'b0;
      active <= 1'b0; intDoneEn <= 1'b0; intRxEn <= 1'b0; threeWire <= 1'b0;
      csPolLine <= '0; divReg <= '0;
    end else begin
      if (wrCtrl) begin
        csSel       <= busWrData[1:0];
        cpha        <= busWrData[2];
        cpol        <= busWrData[3];
        csPolShared <= busWrData[6];
        active      <= busWrData[7];
        intDoneEn   <= busWrData[9];
        intRxEn     <= busWrData[10];
        threeWire   <= busWrData[12];
        csPolLine   <= busWrData[21 +: NUM_CS];
      end
      if (busWrEn && regSel == SEL_DIV) divReg <= {busWrData[DIV_W-1:1], 1'b0};
    end
  end

  assign strb.txPush = busWrEn && (regSel == SEL_DATA);
  assign strb.rxPop  = busRdEn && (regSel == SEL_DATA);
  assign strb.clrTx  = wrCtrl && busWrData[B_CLRTX];
  assign strb.clrRx  = wrCtrl && busWrData[B_CLRRX];
  assign strb.wrByte = busWrData[WORD_W-1:0];

  assign cfg.active      = active;
  assign cfg.cpol        = cpol;
  assign cfg.cpha        = cpha;
  assign cfg.threeWireRd = threeWire;
  assign cfg.halfLen     = (divReg[DIV_W-1:1] == '0) ? {1'b1, {(DIV_W-1){1'b0}}}
                                                     : {1'b0, divReg[DIV_W-1:1]};

  assign done = !stat.busy && stat.txEmpty;
  assign irq  = active && ((done && intDoneEn) || (stat.rxHigh && intRxEn));

  always_comb begin
    ctrlWord        = '0;
    ctrlWord[1:0]   = csSel;
    ctrlWord[2]     = cpha;
    ctrlWord[3]     = cpol;
    ctrlWord[6]     = csPolShared;
    ctrlWord[7]     = active;
    ctrlWord[9]     = intDoneEn;
    ctrlWord[10]    = intRxEn;
    ctrlWord[12]    = threeWire;
    ctrlWord[16]    = done;
    ctrlWord[17]    = !stat.rxEmpty;
    ctrlWord[18]    = !stat.txFull;
    ctrlWord[19]    = stat.rxHigh;
    ctrlWord[20]    = stat.rxFull;
    ctrlWord[21 +: NUM_CS] = csPolLine;
  end

  always_comb begin
    case (regSel)
      SEL_CTRL: rdNext = ctrlWord;
      SEL_DATA: rdNext = stat.rxEmpty ? '0 : BUS_W'(stat.rxHead);
      SEL_DIV:  rdNext = BUS_W'(divReg);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdNext;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : gCs
    logic pick, highLvl;
    assign pick       = (csSel == 2'(i));
    assign highLvl    = csPolLine[i] | (csPolShared & pick);
    assign chipSel[i] = (active & pick) ? highLvl : ~highLvl;
  end

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $stable(csSel) && $stable(csPolLine) && $stable(csPolShared))
      |-> $stable(chipSel)); // R4
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(active) && stat.txEmpty && !stat.busy && intDoneEn) |-> irq); // R5
endmodule

// File: rtl/spiRegMaster.sv
module spiRegMaster import spiRegPkg::*; #(
  parameter int ADDR_W     = 4,
  parameter int BUS_W      = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic              sclk,
  output logic              mosi,
  output logic              mosiOe,
  input  logic              mosiIn,
  input  logic              miso,
  output logic [NUM_CS-1:0] chipSel,
  output logic              irq
);
  strobe_t strb;
  cfg_t    cfg;
  stat_t   stat;

  spiRegs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .stat(stat), .strb(strb),
    .cfg(cfg), .chipSel(chipSel), .irq(irq));

  spiShift #(.FIFO_DEPTH(FIFO_DEPTH)) shift_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .misoIn(miso),
    .dataPinIn(mosiIn), .stat(stat), .sclk(sclk), .mosi(mosi), .mosiOe(mosiOe));
endmodule

// File: tb/spiRegMaster_tb.sv
module spiRegMaster_tb_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_DIV = 4'h8, A_LEN = 4'hC;
  localparam logic [31:0] CLRTX = 32'h10, CLRRX = 32'h20, ACT = 32'h80, SHPOL = 32'h40,
                          INTD = 32'h200, INTR = 32'h400, TW = 32'h1000,
                          L0 = 32'h200000, L2 = 32'h800000;
  // {cpol, cpha, divider, byte sent, byte answered}
  localparam logic [25:0] VEC [5] = '{
    {1'b0, 1'b0, 8'd2, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'd4, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'd2, 8'hC3, 8'h18},
    {1'b1, 1'b1, 8'd6, 8'h01, 8'h80},
    {1'b0, 1'b0, 8'd2, 8'hFF, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0, busRdData;
  logic sclk, mosi, mosiOe, mosiIn, miso, irq;
  logic [2:0] chipSel;
  int checks = 0, fails = 0;

  // device model
  logic slvCpol = 1'b0, slvCpha = 1'b0, tieMiso = 1'b0;
  logic [7:0] slvResp = '0;
  logic loadTick = 1'b0;
  logic [7:0] slvTx = '0, slvRx = '0;
  logic slvFirst = 1'b1, prevSclk = 1'b0, prevLoad = 1'b0;

  always #5 clk = ~clk;

  spiRegMaster dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .sclk(sclk), .mosi(mosi),
    .mosiOe(mosiOe), .mosiIn(mosiIn), .miso(miso), .chipSel(chipSel), .irq(irq));

  assign mosiIn = mosiOe ? mosi : slvTx[7];
  assign miso   = tieMiso ? 1'b0 : slvTx[7];

  always @(sclk or loadTick) begin
    if (loadTick != prevLoad) begin
      prevLoad = loadTick;
      slvTx    = slvResp;
      slvRx    = '0;
      slvFirst = 1'b1;
      prevSclk = sclk;
    end else if (sclk !== prevSclk) begin
      prevSclk = sclk;
      if (sclk != slvCpol) begin
        if (!slvCpha) slvRx = {slvRx[6:0], mosi};
        else begin
          if (!slvFirst) slvTx = {slvTx[6:0], 1'b0};
          slvFirst = 1'b0;
        end
      end else begin
        if (!slvCpha) slvTx = {slvTx[6:0], 1'b0};
        else slvRx = {slvRx[6:0], mosi};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CTRL, v);
      if (v[16]) break;
    end
  endtask

  task automatic slvLoad(input logic pol, input logic pha, input logic [7:0] resp);
    slvCpol = pol; slvCpha = pha; slvResp = resp;
    loadTick = ~loadTick;
    #1;
  endtask

  task automatic measureHalf(input logic idleLvl, output int n);
    logic s;
    for (int i = 0; i < 40000 && sclk == idleLvl; i++) @(negedge clk);
    s = sclk; n = 0;
    for (int i = 0; i < 40000 && sclk == s; i++) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkReset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 control after reset", v, 32'h00050000);
    rd(A_DIV, v);  chk("R1 divider after reset", v, 32'h0);
    chk("R1 pins after reset {chipSel,sclk,irq}", {27'b0, chipSel, sclk, irq}, 32'h1C);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    doReset();
    checkReset();

    // main function over the vector table
    foreach (VEC[k]) begin
      logic [31:0] mode;
      mode = {28'b0, VEC[k][25], VEC[k][24], 2'b00};
      wr(A_DIV, {24'b0, VEC[k][23:16]});
      wr(A_CTRL, CLRTX | CLRRX | mode);
      repeat (3) @(negedge clk);
      slvLoad(VEC[k][25], VEC[k][24], VEC[k][7:0]);
      wr(A_DATA, {24'b0, VEC[k][15:8]});
      wr(A_CTRL, ACT | mode);
      waitDone();
      rd(A_DATA, v);
      chk($sformatf("R2 received byte, vector %0d", k), v, {24'b0, VEC[k][7:0]});
      chk($sformatf("R2 device saw MSB-first byte, vector %0d", k), {24'b0, slvRx}, {24'b0, VEC[k][15:8]});
      chk($sformatf("R2 clock idles at polarity, vector %0d", k), {31'b0, sclk}, {31'b0, VEC[k][25]});
      wr(A_CTRL, mode);
    end

    // R3 divider
    wr(A_DIV, 32'd5);
    rd(A_DIV, v); chk("R3 divider bit 0 ignored", v, 32'd4);
    wr(A_DIV, 32'd6);
    wr(A_CTRL, CLRTX | CLRRX);
    wr(A_DATA, 32'h5A);
    wr(A_CTRL, ACT);
    measureHalf(1'b0, n);
    chk("R3 half period for divider 6", n, 32'd3);
    waitDone();
    wr(A_CTRL, CLRRX);

    // R12 length stub
    wr(A_LEN, 32'hFF);
    rd(A_LEN, v); chk("R12 length register reads zero", v, 32'h0);

    // R5 / R6 done at once with empty queue
    wr(A_CTRL, ACT | INTD);
    chk("R5 irq at once with empty queue", {31'b0, irq}, 32'h1);
    rd(A_CTRL, v); chk("R5 idle flag", {31'b0, v[16]}, 32'h1);
    wr(A_CTRL, INTD);
    chk("R6 irq gated by run flag", {31'b0, irq}, 32'h0);

    // R4 chip selects
    wr(A_CTRL, ACT | 32'd1);
    chk("R4 line 1 low-active asserted", {29'b0, chipSel}, 32'h5);
    wr(A_CTRL, ACT | L2);
    chk("R4 line 2 active-high idle", {29'b0, chipSel}, 32'h2);
    wr(A_CTRL, ACT | SHPOL | L0 | 32'd1);
    chk("R4 shared polarity on selected line", {29'b0, chipSel}, 32'h6);
    wr(A_CTRL, SHPOL | L0 | 32'd1);
    chk("R4 released with shared polarity", {29'b0, chipSel}, 32'h4);
    wr(A_CTRL, ACT | 32'd3);
    chk("R4 select value 3 drives none", {29'b0, chipSel}, 32'h7);
    wr(A_DIV, 32'd2);
    wr(A_CTRL, CLRTX | CLRRX);
    wr(A_DATA, 32'h11);
    wr(A_DATA, 32'h22);
    wr(A_CTRL, ACT);
    waitDone();
    chk("R4 select held after bytes", {29'b0, chipSel}, 32'h6);
    wr(A_CTRL, 32'h0);
    chk("R4 select dropped with run flag", {29'b0, chipSel}, 32'h7);
    rd(A_DATA, v);
    rd(A_DATA, v);
    rd(A_CTRL, v); chk("R8 receive empty after two reads", {31'b0, v[17]}, 32'h0);

    // R7 / R8 / R11 queue limits
    wr(A_CTRL, CLRTX | CLRRX);
    for (int i = 0; i < 17; i++) wr(A_DATA, 32'(i));
    rd(A_CTRL, v); chk("R8 transmit full flag", {31'b0, v[18]}, 32'h0);
    wr(A_CTRL, ACT);
    waitDone();
    rd(A_CTRL, v);
    chk("R7 write to full queue dropped", {31'b0, v[16]}, 32'h1);
    chk("R8 receive flags bits 20:17", {28'b0, v[20:17]}, 32'hF);
    wr(A_CTRL, ACT | INTR);
    chk("R6 receive interrupt", {31'b0, irq}, 32'h1);
    wr(A_DATA, 32'h55);
    repeat (40) @(negedge clk);
    rd(A_CTRL, v); chk("R11 stalled on full receive", {31'b0, v[16]}, 32'h0);
    rd(A_DATA, v);
    waitDone();
    rd(A_CTRL, v); chk("R11 resumed after read", {31'b0, v[20]}, 32'h1);
    for (int i = 0; i < 4; i++) rd(A_DATA, v);
    rd(A_CTRL, v); chk("R8 threshold at 12", {31'b0, v[19]}, 32'h1);
    rd(A_DATA, v);
    rd(A_CTRL, v); chk("R8 threshold below 12", {31'b0, v[19]}, 32'h0);
    chk("R6 receive interrupt clears", {31'b0, irq}, 32'h0);

    // R9 clears
    wr(A_CTRL, ACT | INTR | CLRRX);
    rd(A_CTRL, v);
    chk("R9 receive cleared", {31'b0, v[17]}, 32'h0);
    chk("R9 clear bits read zero", {30'b0, v[5:4]}, 32'h0);
    rd(A_DATA, v); chk("R7 empty read returns zero", v, 32'h0);
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'hAA);
    rd(A_CTRL, v); chk("R9 queue holds bytes before clear", {31'b0, v[16]}, 32'h0);
    wr(A_CTRL, CLRTX);
    rd(A_CTRL, v); chk("R9 transmit cleared", {30'b0, v[18], v[16]}, 32'h3);

    // R10 three-wire
    wr(A_CTRL, CLRTX | CLRRX);
    tieMiso = 1'b1;
    repeat (2) @(negedge clk);
    slvLoad(1'b0, 1'b0, 8'h96);
    wr(A_DATA, 32'h3C);
    wr(A_CTRL, ACT | TW);
    chk("R10 pin released", {31'b0, mosiOe}, 32'h0);
    waitDone();
    rd(A_DATA, v); chk("R10 byte taken from data pin", v, 32'h96);
    wr(A_CTRL, 32'h0);
    tieMiso = 1'b0;
    chk("R10 pin driven again", {31'b0, mosiOe}, 32'h1);

    // R3 slowest rate
    wr(A_DIV, 32'h0);
    wr(A_CTRL, CLRTX | CLRRX);
    wr(A_DATA, 32'h80);
    wr(A_CTRL, ACT);
    measureHalf(1'b0, n);
    chk("R3 divider zero half period", n, 32'd32768);

    doReset();
    checkReset();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule